// File: doc/BRIEF.md
# Four-Bit High-Drive Port with Motor Pattern Mode

This block is a small memory-mapped port of four pins. Each pin can be an input or an output. Two direction bits in a control register set the directions. The three low pins share one direction bit and the top pin has its own. Software writes an output pattern into a data register. A read of that register returns the stored value for output pins and the synchronised pin level for input pins.

The top pin can carry a square wave in place of its data bit. The square wave comes from a free-running divider. A 2-bit select picks its rate, and a build parameter can tie the pin to this function for good. In motor mode, the output pins stay high while an external timer is idle. They show the stored pattern only while that timer counts, so a stepper pattern loaded in advance appears in step with the timer.

Top module: `hd_port`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0000), the control register reads 0000 and the data register holds 0000.
- R2: The control register is at `bus_addr` = 1. Its bit 0 sets the direction of pins 0 to 2 together and its bit 2 sets the direction of pin 3; 1 means output. Bits 1 and 3 read as 0.
- R3: A write to the data register (`bus_addr` = 0) changes only the bits whose pins are currently outputs. The other stored bits keep their value.
- R4: A read of the data register returns the stored bit for output pins and, for input pins, the pin level as it was two clock edges earlier.
- R5: With motor mode and the frequency output both off, each output pin drives its stored data bit, one cycle after the write.
- R6: With motor mode on and `timer_run` low, every output pin among 0 to 3 drives 1, including after the timer stops.
- R7: With motor mode on and `timer_run` high, the output pins drive the stored data bits.
- R8: With `fout_en` high, pin 3 is an output whatever its direction bit, and it carries the selected frequency instead of its data bit.
- R9: `fout_sel` picks the rate. 00 gives the parameterised low rate (default: period 32 clocks, 50% duty). 01 gives the system clock itself. 10 gives period 2 clocks. 11 gives period 8 clocks, high for 4.
- R10: With `FORCE_FOUT` = 1, pin 3 is always the frequency output, even with `fout_en` low.
- R11: The frequency output takes priority over motor mode on pin 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the fastest frequency output |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the data register, 1 the control register |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data of the addressed register, combinational |
| pin_in | input | 4 | Levels seen at the pins |
| timer_run | input | 1 | High while the external timer counts |
| motor_en | input | 1 | Motor pattern mode enable |
| fout_en | input | 1 | Frequency output enable for pin 3 |
| fout_sel | input | 2 | Frequency select |
| pin_out | output | 4 | Levels to drive on the pins |
| pin_oe | output | 4 | Per-pin output enable |

## Verification
A register write shows up in the register read-back and at the pins one clock edge later. A change of `timer_run`, `motor_en`, `fout_en` or `fout_sel` reaches the pins in the same cycle. An input pin level appears on a data read after two edges. The driver records each expected value with the cycle in which it falls due. The monitor compares it at the falling edge of exactly that cycle, so there is no polling window. The frequency rates are checked from runs of falling-edge samples: each sample is compared with the ones a half period and a full period later. The system-clock rate is checked by sampling pin 3 in the high and low phases of the clock.

// File: rtl/hd_port_pkg.sv
`timescale 1ns/1ps
package hd_port_pkg;

    localparam int unsigned PORT_W = 4;

    typedef enum logic [1:0] {
        FSEL_LOW    = 2'b00,
        FSEL_SYS    = 2'b01,
        FSEL_HALF   = 2'b10,
        FSEL_EIGHTH = 2'b11
    } fsel_e;

    typedef enum logic [1:0] {
        LOW_1K  = 2'd0,
        LOW_512 = 2'd1,
        LOW_128 = 2'd2,
        LOW_32  = 2'd3
    } low_rate_e;

    typedef struct packed {
        logic dir_hi;
        logic dir_lo;
    } ctrl_t;

    // Divider tap for the low rate; tap k gives a period of 2^(k+1) clocks.
    function automatic int unsigned low_tap(low_rate_e r);
        case (r)
            LOW_1K:  return 4;
            LOW_512: return 5;
            LOW_128: return 7;
            default: return 9;
        endcase
    endfunction

    function automatic logic [PORT_W-1:0] dir_mask(ctrl_t c);
        return {c.dir_hi, {(PORT_W-1){c.dir_lo}}};
    endfunction

    function automatic logic [PORT_W-1:0] ctrl_word(ctrl_t c);
        return {1'b0, c.dir_hi, 1'b0, c.dir_lo};
    endfunction

endpackage

// File: rtl/hd_port_sync.sv
`timescale 1ns/1ps
module hd_port_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hd_port_freqgen.sv
`timescale 1ns/1ps
module hd_port_freqgen
    import hd_port_pkg::*;
#(
    parameter low_rate_e LOW_RATE = LOW_1K
) (
    input  logic  clk,
    input  logic  rst,
    input  fsel_e sel,
    output logic  freq
);
    localparam int unsigned LOW_TAP = low_tap(LOW_RATE);
    localparam int unsigned DIV_W   = LOW_TAP + 1;

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    always_comb begin
        unique case (sel)
            FSEL_LOW:    freq = cnt[LOW_TAP];
            FSEL_SYS:    freq = clk;
            FSEL_HALF:   freq = cnt[0];
            FSEL_EIGHTH: freq = cnt[2];
            default:     freq = 1'b0;
        endcase
    end
endmodule

// File: rtl/hd_port_regs.sv
`timescale 1ns/1ps
module hd_port_regs
    import hd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr_ctrl,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output ctrl_t             ctrl_q,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] rdata
);
    logic [PORT_W-1:0] out_mask;

    assign out_mask = dir_mask(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else if (we) begin
            if (addr_ctrl) begin
                ctrl_q.dir_lo <= wdata[0];
                ctrl_q.dir_hi <= wdata[2];
            end else begin
                data_q <= (data_q & ~out_mask) | (wdata & out_mask);
            end
        end
    end

    always_comb begin
        if (addr_ctrl) rdata = ctrl_word(ctrl_q);
        else           rdata = (data_q & out_mask) | (pin_sync & ~out_mask);
    end

    // R3: stored bits of input pins survive a data write
    assert_keep_low_R3: assert property (@(posedge clk) disable iff (rst)
        (we && !addr_ctrl && !ctrl_q.dir_lo) |=> (data_q[2:0] == $past(data_q[2:0])));
    assert_keep_high_R3: assert property (@(posedge clk) disable iff (rst)
        (we && !addr_ctrl && !ctrl_q.dir_hi) |=> (data_q[3] == $past(data_q[3])));
endmodule

// File: rtl/hd_port_pinmux.sv
`timescale 1ns/1ps
module hd_port_pinmux
    import hd_port_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [PORT_W-1:0] data,
    input  logic              motor_en,
    input  logic              timer_run,
    input  logic              fout_active,
    input  logic              freq,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    logic motor_hold;

    assign motor_hold = motor_en && !timer_run;

    always_comb begin
        pin_oe  = dir_mask(ctrl);
        pin_out = motor_hold ? '1 : data;
        if (fout_active) begin
            pin_out[PORT_W-1] = freq;
            pin_oe[PORT_W-1]  = 1'b1;
        end
    end
endmodule

// File: rtl/hd_port.sv
`timescale 1ns/1ps
module hd_port
    import hd_port_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter low_rate_e   LOW_RATE    = LOW_1K,
    parameter bit          FORCE_FOUT  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    input  logic [3:0] pin_in,
    input  logic       timer_run,
    input  logic       motor_en,
    input  logic       fout_en,
    input  logic [1:0] fout_sel,
    output logic [3:0] pin_out,
    output logic [3:0] pin_oe
);
    ctrl_t             ctrl_q;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] pin_sync;
    logic              freq;
    logic              fout_active;
    fsel_e             sel;

    assign sel         = fsel_e'(fout_sel);
    assign fout_active = FORCE_FOUT || fout_en;

    hd_port_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    hd_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr_ctrl (bus_addr),
        .wdata     (bus_wdata),
        .pin_sync  (pin_sync),
        .ctrl_q    (ctrl_q),
        .data_q    (data_q),
        .rdata     (bus_rdata)
    );

    hd_port_freqgen #(.LOW_RATE(LOW_RATE)) u_freq (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .freq (freq)
    );

    hd_port_pinmux u_mux (
        .ctrl        (ctrl_q),
        .data        (data_q),
        .motor_en    (motor_en),
        .timer_run   (timer_run),
        .fout_active (fout_active),
        .freq        (freq),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // R1: first cycle after reset has no driven pin unless the frequency output owns pin 3
    assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !fout_active) |-> (pin_oe == 4'b0000));

    // R2: the three low pins always share one direction
    assert_dir_group_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[2:0] == 3'b000) || (pin_oe[2:0] == 3'b111));

    // R6: idle timer in motor mode holds every driven low pin high
    assert_motor_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (motor_en && !timer_run) |-> ((pin_out[2:0] | ~pin_oe[2:0]) == 3'b111));

    // R8: frequency output always drives pin 3
    assert_fout_drives_R8: assert property (@(posedge clk) disable iff (rst)
        fout_active |-> pin_oe[3]);

    // R9: the two-clock rate changes level on every edge
    assert_half_rate_R9: assert property (@(posedge clk) disable iff (rst)
        (fout_active && sel == FSEL_HALF && $past(fout_active && sel == FSEL_HALF) && !$past(rst))
        |-> (pin_out[3] != $past(pin_out[3])));
endmodule

// File: tb/hd_port_bench.sv
`timescale 1ns/1ps
module hd_port_bench;
    import hd_port_pkg::*;

    localparam int W_OUT  = 0;
    localparam int W_OE   = 1;
    localparam int W_RD   = 2;
    localparam int W_FOE  = 3;
    localparam int W_FOUT = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_we;
    logic       bus_addr;
    logic [3:0] bus_wdata;
    logic [3:0] bus_rdata, f_rdata;
    logic [3:0] pin_in;
    logic       timer_run, motor_en, fout_en;
    logic [1:0] fout_sel;
    logic [3:0] pin_out, pin_oe, f_out, f_oe;

    always #10 clk = ~clk;

    hd_port u_hd_port (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .timer_run(timer_run), .motor_en(motor_en), .fout_en(fout_en),
        .fout_sel(fout_sel), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    hd_port #(.FORCE_FOUT(1'b1)) u_hd_port_forced (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(f_rdata), .pin_in(pin_in),
        .timer_run(timer_run), .motor_en(motor_en), .fout_en(fout_en),
        .fout_sel(fout_sel), .pin_out(f_out), .pin_oe(f_oe)
    );

    typedef struct {
        string      req;
        int         due;
        int         what;
        logic [3:0] exp;
    } item_t;

    item_t q[$];
    item_t mon_it;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    logic smp [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic expect_at(string req, int what, logic [3:0] v, int ofs);
        q.push_back('{req, cyc + ofs, what, v});
    endtask

    // monitor: compare each expectation at the falling edge of its due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            mon_it = q.pop_front();
            case (mon_it.what)
                W_OUT:   chk(mon_it.req, pin_out, mon_it.exp);
                W_OE:    chk(mon_it.req, pin_oe, mon_it.exp);
                W_RD:    chk(mon_it.req, bus_rdata, mon_it.exp);
                W_FOE:   chk(mon_it.req, f_oe, mon_it.exp);
                default: chk(mon_it.req, {3'b000, f_out[3]}, mon_it.exp);
            endcase
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic a, logic [3:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        step();
        bus_we    = 1'b0;
    endtask

    task automatic grab(int n, logic use_forced);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp[i] = use_forced ? f_out[3] : pin_out[3];
        end
        step();
    endtask

    // half: samples apart by half a period differ, by a full period agree
    task automatic period_check(string req, int half, int n);
        logic ok = 1'b1;
        for (int i = 0; i + 2 * half < n; i++) begin
            if (smp[i + half] == smp[i]) ok = 1'b0;
            if (smp[i + 2 * half] != smp[i]) ok = 1'b0;
        end
        chk(req, {3'b000, ok}, 4'b0001);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = 4'h0;
        pin_in = 4'h0; timer_run = 1'b0; motor_en = 1'b0; fout_en = 1'b0;
        fout_sel = 2'b00;
        step(); step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        expect_at("R1 oe", W_OE, 4'b0000, 0);
        bus_addr = 1'b1;
        expect_at("R1 ctrl", W_RD, 4'b0000, 0);
        step();
        wr(1'b1, 4'b0101);
        bus_addr = 1'b0;
        expect_at("R1 data reg zero", W_RD, 4'b0000, 0);
        expect_at("R2 all outputs", W_OE, 4'b1111, 0);
        step();

        // R2 unused control bits
        wr(1'b1, 4'b1111);
        bus_addr = 1'b1;
        expect_at("R2 ctrl readback", W_RD, 4'b0101, 0);
        step();

        // R5 plain output
        wr(1'b0, 4'b1010);
        expect_at("R5 pins", W_OUT, 4'b1010, 0);
        expect_at("R4 output read", W_RD, 4'b1010, 0);
        step();

        // R3 pin 3 input: its stored bit must survive
        wr(1'b1, 4'b0001);
        expect_at("R2 low only", W_OE, 4'b0111, 0);
        step();
        wr(1'b0, 4'b0101);
        expect_at("R3 low written", W_OUT, 4'b1101, 0);
        expect_at("R4 mixed read", W_RD, 4'b0101, 0);
        step();
        wr(1'b1, 4'b0101);
        expect_at("R3 bit3 kept", W_OUT, 4'b1101, 0);
        step();

        // R3 low pins input: low stored bits survive
        wr(1'b1, 4'b0100);
        expect_at("R2 high only", W_OE, 4'b1000, 0);
        step();
        wr(1'b0, 4'b0010);
        step();
        wr(1'b1, 4'b0101);
        expect_at("R3 low kept", W_OUT, 4'b0101, 0);
        step();

        // R4 input pins through the synchroniser
        wr(1'b1, 4'b0100);
        pin_in = 4'b0110;
        bus_addr = 1'b0;
        expect_at("R4 sync not yet", W_RD, 4'b0000, 0);
        expect_at("R4 sync after two", W_RD, 4'b0110, 2);
        step(); step(); step();

        // R6/R7 motor mode
        wr(1'b1, 4'b0101);
        wr(1'b0, 4'b0110);
        motor_en = 1'b1;
        expect_at("R6 idle ones", W_OUT, 4'b1111, 0);
        step();
        timer_run = 1'b1;
        expect_at("R7 pattern", W_OUT, 4'b0110, 0);
        step();
        timer_run = 1'b0;
        expect_at("R6 after timer", W_OUT, 4'b1111, 0);
        step();
        motor_en = 1'b0;
        expect_at("R5 motor off", W_OUT, 4'b0110, 0);
        step();

        // R8/R9 frequency output
        wr(1'b1, 4'b0001);
        fout_en = 1'b1;
        fout_sel = 2'b10;
        expect_at("R8 pin3 driven", W_OE, 4'b1111, 0);
        step();
        grab(16, 1'b0);
        period_check("R9 sel10 period 2", 1, 16);
        fout_sel = 2'b11;
        step();
        grab(32, 1'b0);
        period_check("R9 sel11 period 8", 4, 32);
        fout_sel = 2'b00;
        step();
        grab(64, 1'b0);
        period_check("R9 sel00 period 32", 16, 64);
        fout_sel = 2'b01;
        step();
        chk("R9 sel01 clock high", {3'b000, pin_out[3]}, 4'b0001);
        @(negedge clk); #2;
        chk("R9 sel01 clock low", {3'b000, pin_out[3]}, 4'b0000);
        step();

        // R11 priority over motor mode
        fout_sel = 2'b10;
        motor_en = 1'b1;
        timer_run = 1'b0;
        step();
        grab(8, 1'b0);
        period_check("R11 pin3 still toggles", 1, 8);
        chk("R11 low pins held", {1'b0, pin_out[2:0]}, 4'b0111);
        motor_en = 1'b0;

        // R10 forced frequency output
        fout_en = 1'b0;
        step();
        expect_at("R8 off releases pin3", W_OE, 4'b0111, 0);
        expect_at("R10 forced oe", W_FOE, 4'b1111, 0);
        step();
        grab(16, 1'b1);
        period_check("R10 forced toggles", 1, 16);

        step(); step();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule